// File: doc/BRIEF.md
# I2C Burst Transfer Sequencer

The sequencer lets software start a short I2C master transaction with a single write to its control register. That write can describe up to four bytes. The block stores outgoing and incoming bytes in a four-entry FIFO buffer. It runs the whole burst by issuing commands to a byte-level bus engine: open with an address, move one byte, or close with a stop. The engine answers each command with an ack or a nack.

Several control bits shape the burst:

- Two bits give the byte count.
- One bit selects the direction.
- The chain and repeated-start bits decide whether a stop follows each byte.
- A halt bit closes a bus that an earlier chained burst left open.

A nack ends the burst early. It records an error and a sticky abort flag, and the transfer-count register reports how many bytes completed. A level interrupt can be raised when a burst completes or when a halt is serviced. Each source has its own mask bit, and both sit behind a master enable. Software clears status bits by writing ones. A soft-reset register returns every register to its reset value except the master address.

Top module: `i2c_burst_seq`

Register byte offsets:

| Offset | Register |
|---|---|
| 0 | data buffer |
| 1 | master address |
| 2 | control |
| 3 | mode |
| 4 | status |
| 5 | extended status |
| 6 | transfer count |
| 7 | interrupt mask |
| 8 | extended control |
| 9 | direct control |

Engine command codes on `cmd_op`: 0 open, 1 write a byte, 2 read a byte, 3 stop.

## Requirements
- R1: After reset, each register reads as follows.
  - Status reads 0x00.
  - Extended status reads 0x40 (bus-free code 4 in bits 6:4).
  - Direct control reads 0x0F.
  - Control and transfer count read 0x00.
  - `irq` is low.
- R2: Each write to offset 0 pushes a byte into the buffer, up to four bytes. Further writes are dropped.
  - A read of offset 0 pops the oldest byte, or returns 0xFF when the buffer is empty.
  - Status bit 5 is set while the buffer holds any byte. Status bit 4 is set while it holds four.
- R3: A control write with bit 0 set and bit 1 clear sends bits 5:4 plus one bytes from the buffer, in order.
  - Before any byte, if the bus is idle, the block issues an open command. Its 7-bit address is master address bits 7:1, and its read flag is control bit 1.
- R4: After each completed byte a stop is issued when control bit 3 is set or bit 2 is clear. Otherwise the bus stays open, and extended status bits 6:4 read 5.
- R5: A burst with control bit 1 set receives its bytes into the buffer. When it ends, the buffer holds exactly the completed bytes, in arrival order.
- R6: A nack on an open or on a byte ends the burst. It sets status bit 2 and extended status bit 0.
  - Offset 6 then holds the number of bytes completed.
  - A later acknowledged open clears status bit 2.
- R7: When a burst completes at least one byte, mode bit 2 is set, and mask bit 0 is set, status bit 1 and `irq` go high and stay high.
- R8: A control write with bit 7 set while the bus is open issues a stop. It also raises status bit 1 and `irq` when mode bit 2 and mask bit 3 are both set. With the bus idle, the halt issues no command.
- R9: Writing ones to status clears only bit 1 (and reserved bit 3). Clearing bit 1 drops `irq`.
- R10: Write masks and readback:
  - Mode stores its write value ANDed with 0x3D.
  - Transfer count stores its write value ANDed with 0x77.
  - Extended status bit 0 clears when written with one (mask 0x8F).
  - Control never reads back bit 0 set.
- R11: Writing one to bit 0 of offset 8 performs a soft reset. It restores the R1 values and empties the buffer, and it keeps the master address.
- R12: Writing mode bit 6 empties the buffer.
- R13: Status bit 0 reads one while a burst or halt is in progress. Register writes made during that time are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops the buffer at offset 0) |
| reg_addr | input | 4 | Register byte offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from `reg_addr` |
| irq | output | 1 | Level interrupt |
| cmd_valid | output | 1 | Engine command request |
| cmd_ready | input | 1 | Engine accepts the command |
| cmd_op | output | 2 | Command code |
| cmd_addr | output | 7 | Target address for an open |
| cmd_read | output | 1 | Direction flag for an open |
| cmd_wdata | output | 8 | Byte to send |
| rsp_done | input | 1 | Command finished pulse |
| rsp_ack | input | 1 | Ack (1) or nack (0) for the finished command |
| rsp_rdata | input | 8 | Received byte for a read command |

## Verification
Random bursts vary four things: length, direction, the chain and repeated-start combination, and the position of a nack (on the open, on any byte, or nowhere). Comparing open, stop and byte command counts with a bench model tells the stop rule apart from the chain rule. It also shows whether a bus left open by one burst correctly skips the next open. Directed cases cover the remaining paths:

- buffer overflow and underflow
- halt with the bus open and with the bus idle
- write masks and the status clear
- writes made while a burst is pending
- soft reset

// File: rtl/i2c_burst_seq.sv
module i2c_burst_seq #(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [AW-1:0] reg_addr,
  input  logic [7:0]    reg_wdata,
  output logic [7:0]    reg_rdata,
  output logic          irq,
  output logic          cmd_valid,
  input  logic          cmd_ready,
  output logic [1:0]    cmd_op,
  output logic [6:0]    cmd_addr,
  output logic          cmd_read,
  output logic [7:0]    cmd_wdata,
  input  logic          rsp_done,
  input  logic          rsp_ack,
  input  logic [7:0]    rsp_rdata
);
  localparam int DEPTH = 4;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [1:0] OP_START = 2'd0, OP_WRITE = 2'd1, OP_READ = 2'd2, OP_STOP = 2'd3;
  localparam logic [AW-1:0] A_DATA = 0, A_MADR = 1, A_CTRL = 2, A_MODE = 3, A_STAT = 4,
                            A_XSTAT = 5, A_XCNT = 6, A_MASK = 7, A_XCTL = 8, A_DIRECT = 9;

  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_WAIT, ST_FIN} st_t;

  st_t         st;
  logic [7:0]  madr, ctrl_q, mode_q, xcnt, mask_q;
  logic [3:0]  direct_q;
  logic [7:0]  buf_q [DEPTH];
  logic [CW-1:0] cnt, done_n;
  logic [1:0]  idx, op_q;
  logic        irqa, err, abort, bus_open, halt_run;

  wire       idle       = (st == ST_IDLE);
  wire [1:0] byte_op    = ctrl_q[1] ? OP_READ : OP_WRITE;
  wire [1:0] n_last     = ctrl_q[5:4];
  wire       stop_after = ctrl_q[3] | ~ctrl_q[2];

  assign cmd_valid = (st == ST_REQ);
  assign cmd_op    = op_q;
  assign cmd_addr  = madr[7:1];
  assign cmd_read  = ctrl_q[1];
  assign cmd_wdata = buf_q[idx];
  assign irq       = irqa;

  always_comb begin
    case (reg_addr)
      A_DATA:   reg_rdata = (cnt == 0) ? 8'hFF : buf_q[0];
      A_MADR:   reg_rdata = madr;
      A_CTRL:   reg_rdata = ctrl_q;
      A_MODE:   reg_rdata = mode_q;
      A_STAT:   reg_rdata = {2'b00, cnt != 0, cnt == CW'(DEPTH), 1'b0, err, irqa, !idle};
      A_XSTAT:  reg_rdata = {1'b0, bus_open ? 3'd5 : 3'd4, 3'b000, abort};
      A_XCNT:   reg_rdata = xcnt;
      A_MASK:   reg_rdata = mask_q;
      A_DIRECT: reg_rdata = {4'h0, direct_q};
      default:  reg_rdata = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE;
      madr <= '0; ctrl_q <= '0; mode_q <= '0; xcnt <= '0; mask_q <= '0;
      direct_q <= 4'hF; cnt <= '0; done_n <= '0; idx <= '0; op_q <= OP_START;
      irqa <= 1'b0; err <= 1'b0; abort <= 1'b0; bus_open <= 1'b0; halt_run <= 1'b0;
      for (int i = 0; i < DEPTH; i++) buf_q[i] <= '0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (reg_wr) begin
            case (reg_addr)
              A_DATA: if (cnt < CW'(DEPTH)) begin
                buf_q[cnt[1:0]] <= reg_wdata;
                cnt <= cnt + 1'b1;
              end
              A_MADR: madr <= reg_wdata;
              A_CTRL: begin
                ctrl_q <= reg_wdata & 8'hFE;
                if (reg_wdata[7] && bus_open) begin
                  op_q <= OP_STOP;
                  halt_run <= 1'b1;
                  st <= ST_REQ;
                  if (mode_q[2] && mask_q[3]) irqa <= 1'b1;
                end else if (reg_wdata[0]) begin
                  idx <= '0;
                  done_n <= '0;
                  op_q <= bus_open ? (reg_wdata[1] ? OP_READ : OP_WRITE) : OP_START;
                  st <= ST_REQ;
                end
              end
              A_MODE: begin
                mode_q <= reg_wdata & 8'h3D;
                if (reg_wdata[6]) begin
                  cnt <= '0;
                  for (int i = 0; i < DEPTH; i++) buf_q[i] <= '0;
                end
              end
              A_STAT:   if (reg_wdata[1]) irqa <= 1'b0;
              A_XSTAT:  if (reg_wdata[0]) abort <= 1'b0;
              A_XCNT:   xcnt <= reg_wdata & 8'h77;
              A_MASK:   mask_q <= reg_wdata;
              A_XCTL: if (reg_wdata[0]) begin
                ctrl_q <= '0; mode_q <= '0; xcnt <= '0; mask_q <= '0; direct_q <= 4'hF;
                irqa <= 1'b0; err <= 1'b0; abort <= 1'b0; cnt <= '0;
                for (int i = 0; i < DEPTH; i++) buf_q[i] <= '0;
              end
              A_DIRECT: direct_q <= reg_wdata[3:0];
              default: ;
            endcase
          end else if (reg_rd && reg_addr == A_DATA && cnt != 0) begin
            for (int i = 0; i < DEPTH - 1; i++) buf_q[i] <= buf_q[i+1];
            buf_q[DEPTH-1] <= '0;
            cnt <= cnt - 1'b1;
          end
        end
        ST_REQ: if (cmd_ready) st <= ST_WAIT;
        ST_WAIT: if (rsp_done) begin
          case (op_q)
            OP_START: begin
              if (rsp_ack) begin
                err <= 1'b0;
                bus_open <= 1'b1;
                op_q <= byte_op;
                st <= ST_REQ;
              end else begin
                err <= 1'b1;
                abort <= 1'b1;
                st <= ST_FIN;
              end
            end
            OP_STOP: begin
              bus_open <= 1'b0;
              if (halt_run) begin
                halt_run <= 1'b0;
                st <= ST_IDLE;
              end else if (idx == n_last) begin
                st <= ST_FIN;
              end else begin
                idx <= idx + 1'b1;
                op_q <= OP_START;
                st <= ST_REQ;
              end
            end
            default: begin
              if (rsp_ack) begin
                if (ctrl_q[1]) buf_q[idx] <= rsp_rdata;
                done_n <= CW'(idx) + 1'b1;
                if (stop_after) begin
                  op_q <= OP_STOP;
                  st <= ST_REQ;
                end else if (idx == n_last) begin
                  st <= ST_FIN;
                end else begin
                  idx <= idx + 1'b1;
                  op_q <= byte_op;
                  st <= ST_REQ;
                end
              end else begin
                err <= 1'b1;
                abort <= 1'b1;
                st <= ST_FIN;
              end
            end
          endcase
        end
        ST_FIN: begin
          xcnt <= 8'(done_n);
          cnt <= done_n;
          if (done_n != 0 && mode_q[2] && mask_q[0]) irqa <= 1'b1;
          st <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  p_cmd_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_op));
  p_start_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_op == OP_START |-> !bus_open);
  p_stop_open_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_op == OP_STOP |-> bus_open);
  p_irq_enable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(mode_q[2]));
  p_buf_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));
  p_fin_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
    st == ST_FIN |-> done_n <= CW'(n_last) + 1'b1);
endmodule

// File: tb/test_i2c_burst_seq.sv
`timescale 1ns/1ps
module test_i2c_burst_seq;
  localparam logic [3:0] A_DATA = 0, A_MADR = 1, A_CTRL = 2, A_MODE = 3, A_STAT = 4,
                         A_XSTAT = 5, A_XCNT = 6, A_MASK = 7, A_XCTL = 8, A_DIRECT = 9;

  logic clk = 0, rst_n = 0;
  logic reg_wr = 0, reg_rd = 0;
  logic [3:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic irq, cmd_valid, cmd_read;
  logic cmd_ready = 0, rsp_done = 0, rsp_ack = 0;
  logic [1:0] cmd_op;
  logic [6:0] cmd_addr;
  logic [7:0] cmd_wdata, rsp_rdata = 0;

  i2c_burst_seq i_i2c_burst_seq (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq), .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready), .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_read(cmd_read),
    .cmd_wdata(cmd_wdata), .rsp_done(rsp_done), .rsp_ack(rsp_ack), .rsp_rdata(rsp_rdata));

  always #2.5 clk = ~clk;

  int nchk = 0, nerr = 0;
  int tot_starts = 0, tot_stops = 0, tot_bytes = 0, eng_bytes = 0;
  int eng_nack_start = 0, eng_nack_byte = 99;
  logic [6:0] last_addr = 0;
  logic last_rd = 0;
  logic [7:0] wr_log [8];
  bit m_open = 0, m_err = 0, m_abort = 0, m_irq = 0, m_ie = 0, m_mk0 = 0;

  initial begin
    #(5.0 * 150000);
    nerr++; nchk++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  // engine model
  initial begin
    forever begin
      @(negedge clk);
      if (cmd_valid) begin
        logic a;
        a = 1'b1;
        cmd_ready = 1;
        case (cmd_op)
          2'd0: begin tot_starts++; a = (eng_nack_start == 0); last_addr = cmd_addr; last_rd = cmd_read; end
          2'd3: tot_stops++;
          default: begin
            tot_bytes++;
            if (eng_bytes < 8) wr_log[eng_bytes] = cmd_wdata;
            a = (eng_bytes != eng_nack_byte);
            rsp_rdata = 8'hA0 + 8'(eng_bytes);
            eng_bytes++;
          end
        endcase
        @(negedge clk);
        cmd_ready = 0;
        repeat ($urandom % 3) @(negedge clk);
        rsp_done = 1; rsp_ack = a;
        @(negedge clk);
        rsp_done = 0;
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); reg_rd = 1; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk); reg_rd = 0;
  endtask

  task automatic wait_idle();
    logic [7:0] v;
    for (int k = 0; k < 5000; k++) begin
      rd(A_STAT, v);
      if (!v[0]) break;
    end
  endtask

  function automatic logic [7:0] xst_exp();
    return {1'b0, m_open ? 3'd5 : 3'd4, 3'b000, m_abort};
  endfunction

  task automatic run_burst(input int n, input bit rdir, input bit ch, input bit rs,
                           input int ns, input int nb);
    logic [7:0] d [4];
    logic [7:0] v;
    int s0, p0, b0, est, esp, eb, edone;
    wr(A_MODE, 8'h40 | (m_ie ? 8'h04 : 8'h00));
    if (!rdir) for (int i = 0; i < 4; i++) begin d[i] = 8'($urandom); wr(A_DATA, d[i]); end
    eng_nack_start = ns; eng_nack_byte = nb; eng_bytes = 0;
    s0 = tot_starts; p0 = tot_stops; b0 = tot_bytes;
    est = 0; esp = 0; eb = 0; edone = 0;
    for (int i = 0; i <= n; i++) begin
      if (!m_open) begin
        est++;
        if (ns != 0) begin m_err = 1; m_abort = 1; break; end
        m_err = 0; m_open = 1;
      end
      eb++;
      if (i == nb) begin m_err = 1; m_abort = 1; break; end
      edone++;
      if (rs || !ch) begin esp++; m_open = 0; end
    end
    if (edone > 0 && m_ie && m_mk0) m_irq = 1;
    wr(A_CTRL, {2'b00, 2'(n), rs, ch, rdir, 1'b1});
    wait_idle();
    rd(A_XCNT, v);  chk("R6 count", v, edone);
    rd(A_STAT, v);  chk("R6 err", v[2], m_err);
    chk("R7 irqa", v[1], m_irq);
    if (rdir) chk("R5 nonempty", v[5], edone > 0);
    if (rdir) chk("R2 full", v[4], edone == 4);
    rd(A_XSTAT, v); chk("R4 xstat", v, xst_exp());
    chk("R3 opens", tot_starts - s0, est);
    chk("R4 stops", tot_stops - p0, esp);
    chk("R3 bytes", tot_bytes - b0, eb);
    chk("R7 irq pin", irq, m_irq);
    if (est > 0) begin chk("R3 addr", last_addr, 7'h52); chk("R3 dir", last_rd, rdir); end
    rd(A_CTRL, v); chk("R10 ctrl bit0", v[0], 0);
    if (!rdir) for (int i = 0; i < edone; i++) chk("R3 data", wr_log[i], d[i]);
    else begin
      for (int i = 0; i < edone; i++) begin rd(A_DATA, v); chk("R5 rx", v, 8'hA0 + 8'(i)); end
      rd(A_DATA, v); chk("R5 empty", v, 8'hFF);
    end
    if (m_irq && ($urandom % 2 == 1)) begin
      wr(A_STAT, 8'h02); m_irq = 0;
      chk("R9 irq drop", irq, 0);
    end
  endtask

  initial begin
    logic [7:0] v;
    int s0, p0;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    rd(A_STAT, v);   chk("R1 stat", v, 8'h00);
    rd(A_XSTAT, v);  chk("R1 xstat", v, 8'h40);
    rd(A_DIRECT, v); chk("R1 direct", v, 8'h0F);
    rd(A_XCNT, v);   chk("R1 xcnt", v, 8'h00);
    rd(A_CTRL, v);   chk("R1 ctrl", v, 8'h00);
    chk("R1 irq", irq, 0);
    // R2 buffer
    for (int i = 0; i < 5; i++) wr(A_DATA, 8'h10 + 8'(i));
    rd(A_STAT, v); chk("R2 flags", v[5:4], 2'b11);
    for (int i = 0; i < 4; i++) begin rd(A_DATA, v); chk("R2 pop", v, 8'h10 + 8'(i)); end
    rd(A_DATA, v); chk("R2 underflow", v, 8'hFF);
    rd(A_STAT, v); chk("R2 flags empty", v[5:4], 2'b00);
    // R12 flush
    wr(A_DATA, 8'h33); wr(A_DATA, 8'h44);
    wr(A_MODE, 8'h40);
    rd(A_STAT, v); chk("R12 flushed", v[5], 0);
    rd(A_DATA, v); chk("R12 empty read", v, 8'hFF);
    // R10 masks
    wr(A_MODE, 8'hFF); rd(A_MODE, v); chk("R10 mode mask", v, 8'h3D);
    wr(A_XCNT, 8'hFF); rd(A_XCNT, v); chk("R10 xcnt mask", v, 8'h77);
    wr(A_CTRL, 8'h7E); rd(A_CTRL, v); chk("R10 ctrl store", v, 8'h7E);
    chk("R8 idle no cmd", tot_starts + tot_stops, 0);
    wr(A_MADR, 8'hA4);
    // directed bursts
    m_ie = 1; m_mk0 = 1; wr(A_MASK, 8'h01);
    run_burst(3, 0, 0, 0, 0, 99);
    run_burst(3, 1, 0, 0, 0, 99);
    run_burst(2, 0, 1, 1, 0, 99);
    run_burst(3, 1, 1, 0, 0, 99);
    run_burst(1, 0, 1, 0, 0, 99);
    run_burst(3, 0, 0, 0, 0, 2);
    run_burst(1, 1, 0, 0, 1, 99);
    // R9 clear only bit1
    wr(A_STAT, 8'hFF); m_irq = 0;
    rd(A_STAT, v); chk("R9 err kept", v[2], 1); chk("R9 irqa clr", v[1], 0);
    chk("R9 irq pin", irq, 0);
    // R10 xstat W1C
    wr(A_XSTAT, 8'h01); m_abort = 0;
    rd(A_XSTAT, v); chk("R10 xstat w1c", v, xst_exp());
    // R6 successful open clears err
    run_burst(0, 0, 0, 0, 0, 99);
    // random
    for (int t = 0; t < 40; t++) begin
      m_ie = $urandom % 2; m_mk0 = $urandom % 2;
      wr(A_MASK, {7'b0, m_mk0});
      run_burst($urandom % 4, $urandom % 2, $urandom % 2, $urandom % 2,
                ($urandom % 8 == 0), $urandom % 8);
    end
    // R13 pending and ignored write
    wr(A_MASK, 8'h01); m_mk0 = 1; m_ie = 1;
    wr(A_MODE, 8'h44);
    if (m_open) begin wr(A_CTRL, 8'h80); wait_idle(); m_open = 0; end
    eng_nack_start = 0; eng_nack_byte = 99; eng_bytes = 0;
    wr(A_CTRL, 8'h31);
    rd(A_STAT, v); chk("R13 pending", v[0], 1);
    wr(A_MASK, 8'h55);
    wait_idle();
    rd(A_MASK, v); chk("R13 write ignored", v, 8'h01);
    wr(A_STAT, 8'h02);
    // R8 halt with open bus
    wr(A_MODE, 8'h44);
    run_burst(0, 0, 1, 0, 0, 99);
    wr(A_STAT, 8'h02); m_irq = 0;
    wr(A_MASK, 8'h08);
    p0 = tot_stops; s0 = tot_starts;
    wr(A_CTRL, 8'h80); wait_idle();
    chk("R8 halt stop", tot_stops - p0, 1);
    chk("R8 halt irq", irq, 1);
    rd(A_XSTAT, v); chk("R8 bus free", v[6:4], 3'd4);
    wr(A_STAT, 8'h02);
    p0 = tot_stops;
    wr(A_CTRL, 8'h80); repeat (10) @(negedge clk);
    chk("R8 halt idle", tot_stops - p0 + tot_starts - s0, 0);
    chk("R8 no irq idle", irq, 0);
    // R11 soft reset
    wr(A_XCNT, 8'h12); wr(A_DIRECT, 8'h03); wr(A_DATA, 8'h99);
    wr(A_XCTL, 8'h01);
    rd(A_MODE, v);   chk("R11 mode", v, 8'h00);
    rd(A_MASK, v);   chk("R11 mask", v, 8'h00);
    rd(A_XCNT, v);   chk("R11 xcnt", v, 8'h00);
    rd(A_DIRECT, v); chk("R11 direct", v, 8'h0F);
    rd(A_STAT, v);   chk("R11 stat", v, 8'h00);
    rd(A_XSTAT, v);  chk("R11 xstat", v, 8'h40);
    rd(A_MADR, v);   chk("R11 madr kept", v, 8'hA4);
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule